// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command nodes held in main memory and hands the payload of each node to a downstream command consumer. Each node starts with one header word that carries two fields: a payload length in words and a pointer to the next node. The walker fetches the header and then reads the payload words one at a time. It presents each word on a valid/ready stream and then follows the pointer. The walk ends as soon as the current pointer carries the end marker. This test is made before any fetch, so a marked pointer causes no memory access.

A start strobe with an address launches a walk. Memory is reached through a single-request read port. Each request is a one-cycle pulse with a byte address, and the answer returns some cycles later with a valid strobe. While it walks, the block adds up an estimated processing cost for the whole chain. When the walk ends it raises a one-cycle completion pulse, and the cost total stays readable until the next walk starts.

Top module: `dma_chain_walker`

## Requirements
- R1: A header word is split as length = bits 31:24 and next-node pointer = bits 23:0. Headers and payloads are fetched strictly in chain order, and each node is fetched exactly once.
- R2: When bit 23 of the current node pointer is set, the walk ends without a memory request. A start pointer with bit 23 set gives zero requests and a total of 0.
- R3: Every memory byte address is the node pointer or payload address ANDed with 0x1FFFFC. Bits 31:24 of the start address are ignored.
- R4: A node whose length field is 0 produces no output word, and the walker moves straight on to its next pointer.
- R5: The cost total is the sum over all fetched nodes of 10, plus 5 + length for each node whose length is non-zero.
- R6: Payload words leave in order, read from header address + 4, + 8, … with each address wrapping inside the 2 MB region (mask 0x1FFFFC).
- R7: While an output word is held (valid high, ready low), that word and valid stay unchanged and no memory request is issued. No word is dropped or repeated.
- R8: The completion signal is high for exactly one cycle at the end of a walk. The cost total then holds its value until the next accepted start.
- R9: A start strobe that arrives while a walk is in progress is ignored.
- R10: A memory request lasts one cycle. No new request is issued until the previous one has been answered, and no request is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| start_addr_i | input | 32 | First node pointer (low 24 bits used) |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | 21 | Memory byte address, word aligned |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output payload word |
| out_ready_i | input | 1 | Consumer ready |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| cycles_o | output | 32 | Accumulated cost estimate |

## Verification
The bound checker covers the properties that hold on every cycle. It checks that a held output word and its valid stay put and that no read is launched while the word waits. It checks that requests are single pulses and that the interface is quiet when idle. It also checks that the completion pulse lasts one cycle and that the total is frozen between walks. Header decoding, the address masking and wrap, the end-marker test before fetch, zero-length nodes, the cost arithmetic and an ignored start strobe all depend on memory contents. Only the bench's scenarios can show these. It does so with an address scoreboard on the memory port and a data scoreboard on the output stream, under several latencies and backpressure patterns.

// File: rtl/cw_pkg.sv
package cw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HREQ,
        ST_HWAIT,
        ST_PREQ,
        ST_PWAIT,
        ST_POUT,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/cw_word_index.sv
// Splits a node pointer into the end-marker flag and the masked word index.
module cw_word_index #(
    parameter int NODE_W = 24,
    parameter int MEM_AW = 21,
    localparam int WORD_W = MEM_AW - 2
) (
    input  logic [NODE_W-1:0] node_i,
    output logic              end_o,
    output logic [WORD_W-1:0] word_o
);
    logic unused_bits;

    assign end_o       = node_i[NODE_W-1];
    assign word_o      = node_i[MEM_AW-1:2];
    assign unused_bits = ^{node_i[NODE_W-2:MEM_AW], node_i[1:0]};
endmodule

// File: rtl/cw_cost_acc.sv
// Running cost estimate: a fixed charge per node plus a per-block charge.
module cw_cost_acc #(
    parameter int CNT_W      = 32,
    parameter int LEN_W      = 8,
    parameter int NODE_COST  = 10,
    parameter int BLOCK_COST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] total_o
);
    logic [CNT_W-1:0] total_d, total_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        step = CNT_W'(NODE_COST);
        if (len_i != '0) begin
            step = step + CNT_W'(BLOCK_COST) + CNT_W'(len_i);
        end
        total_d = total_q;
        if (clr_i) begin
            total_d = '0;
        end else if (add_i) begin
            total_d = total_q + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
        end else begin
            total_q <= total_d;
        end
    end

    assign total_o = total_q;
endmodule

// File: rtl/cw_out_hold.sv
// Single output holding register on the valid/ready stream.
module cw_out_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load_i) begin
            h_d.vld = 1'b1;
            h_d.dat = data_i;
        end else if (h_q.vld && ready_i) begin
            h_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign valid_o = h_q.vld;
    assign data_o  = h_q.dat;
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
    parameter int NODE_W     = 24,
    parameter int LEN_W      = 8,
    parameter int MEM_AW     = 21,
    parameter int CNT_W      = 32,
    parameter int NODE_COST  = 10,
    parameter int BLOCK_COST = 5,
    localparam int DATA_W    = LEN_W + NODE_W,
    localparam int WORD_W    = MEM_AW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] start_addr_i,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cycles_o
);
    import cw_pkg::*;

    typedef struct packed {
        walk_state_e       st;
        logic [NODE_W-1:0] node;
        logic [WORD_W-1:0] ptr;
        logic [LEN_W-1:0]  left;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic              node_end;
    logic [WORD_W-1:0] node_word;
    logic [WORD_W-1:0] req_word;
    logic [LEN_W-1:0]  hdr_len;
    logic              cost_clr, cost_add, out_load, out_free;
    logic              unused_start_hi;

    assign hdr_len         = mem_rdata_i[DATA_W-1 -: LEN_W];
    assign unused_start_hi = ^start_addr_i[DATA_W-1:NODE_W];
    assign out_free        = !out_valid_o || out_ready_i;

    cw_word_index #(.NODE_W(NODE_W), .MEM_AW(MEM_AW)) u_idx (
        .node_i (r_q.node),
        .end_o  (node_end),
        .word_o (node_word)
    );

    always_comb begin
        r_d      = r_q;
        mem_req_o = 1'b0;
        req_word = r_q.ptr;
        cost_clr = 1'b0;
        cost_add = 1'b0;
        out_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.node = start_addr_i[NODE_W-1:0];
                    cost_clr = 1'b1;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                r_d.st = node_end ? ST_DONE : ST_HREQ;
            end
            ST_HREQ: begin
                mem_req_o = 1'b1;
                req_word  = node_word;
                r_d.st    = ST_HWAIT;
            end
            ST_HWAIT: begin
                if (mem_rvalid_i) begin
                    cost_add = 1'b1;
                    r_d.node = mem_rdata_i[NODE_W-1:0];
                    r_d.ptr  = node_word + WORD_W'(1);
                    r_d.left = hdr_len;
                    r_d.st   = (hdr_len == '0) ? ST_CHECK : ST_PREQ;
                end
            end
            ST_PREQ: begin
                mem_req_o = 1'b1;
                r_d.st    = ST_PWAIT;
            end
            ST_PWAIT: begin
                if (mem_rvalid_i) begin
                    out_load = 1'b1;
                    r_d.ptr  = r_q.ptr + WORD_W'(1);
                    r_d.left = r_q.left - LEN_W'(1);
                    r_d.st   = ST_POUT;
                end
            end
            ST_POUT: begin
                if (out_free) begin
                    r_d.st = (r_q.left == '0) ? ST_CHECK : ST_PREQ;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, node: '0, ptr: '0, left: '0};
        end else begin
            r_q <= r_d;
        end
    end

    cw_cost_acc #(
        .CNT_W(CNT_W), .LEN_W(LEN_W),
        .NODE_COST(NODE_COST), .BLOCK_COST(BLOCK_COST)
    ) u_cost (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cost_clr),
        .add_i   (cost_add),
        .len_i   (hdr_len),
        .total_o (cycles_o)
    );

    cw_out_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (out_load),
        .data_i  (mem_rdata_i),
        .ready_i (out_ready_i),
        .valid_o (out_valid_o),
        .data_o  (out_data_o)
    );

    assign mem_addr_o = {req_word, 2'b00};
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = (r_q.st == ST_DONE);
endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_req_o,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_data_o,
    input logic              out_ready_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  cycles_o
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R7
    AST_NO_READ_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |-> !mem_req_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o); // R8
    AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable(cycles_o)); // R8
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !out_valid_o); // R10
endmodule

bind dma_chain_walker cw_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_chain_walker_test.sv
`timescale 1ns/1ps
module dma_chain_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_req;
    logic [20:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        busy, done;
    logic [31:0] cycles;

    always #10 clk = ~clk;

    dma_chain_walker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata), .out_valid_o(out_valid), .out_data_o(out_data),
        .out_ready_i(out_ready), .busy_o(busy), .done_o(done), .cycles_o(cycles)
    );

    int n_tests = 0;
    int n_fail = 0;
    logic [31:0] exp_data_q[$];
    logic [20:0] exp_addr_q[$];
    logic [31:0] mem [int];
    int          lat = 1;
    int          rmode = 0;
    int          exp_cost = 0;
    int          mem_cnt = 0;
    logic [20:0] mem_pend = '0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and address scoreboard (R3, R10)
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = mem.exists(int'(mem_pend)) ? mem[int'(mem_pend)] : 32'hDEADBEEF;
            end
        end
        if (rst_n && mem_req) begin
            check(mem_cnt == 0 && !mem_rvalid, "R10 request while one outstanding", 32'(mem_cnt), 32'd0);
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R2 unexpected memory request", 32'(mem_addr), 32'hFFFFFFFF);
            end else begin
                logic [20:0] ea;
                ea = exp_addr_q.pop_front();
                check(mem_addr == ea, "R3 fetch address", 32'(mem_addr), 32'(ea));
            end
            mem_pend = mem_addr;
            mem_cnt  = lat;
        end
    end

    // output scoreboard (R6, R7)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R4 unexpected output word", out_data, 32'hFFFFFFFF);
            end else begin
                logic [31:0] ed;
                ed = exp_data_q.pop_front();
                check(out_data == ed, "R6 payload word order", out_data, ed);
            end
        end
    end

    // consumer ready pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rmode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0];
            default: out_ready = lfsr[0] & lfsr[3];
        endcase
    end

    // driver: builds one node and pushes the expected traffic
    task automatic add_node(input logic [23:0] a, input logic [7:0] len,
                            input logic [23:0] nxt, input logic [7:0] tag);
        logic [20:0] h;
        logic [20:0] p;
        logic [31:0] w;
        h = a[20:0] & 21'h1FFFFC;
        mem[int'(h)] = {len, nxt};
        exp_addr_q.push_back(h);
        exp_cost += 10;
        if (len != 0) exp_cost += 5 + int'(len);
        for (int i = 0; i < int'(len); i++) begin
            p = (h + 21'(4 * (i + 1))) & 21'h1FFFFC;
            w = {tag, 8'h5C, 16'(i)};
            mem[int'(p)] = w;
            exp_addr_q.push_back(p);
            exp_data_q.push_back(w);
        end
    endtask

    task automatic run_chain(input logic [31:0] sa, input bit poke);
        int t;
        @(posedge clk); #1;
        start = 1'b1; start_addr = sa;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (6) @(posedge clk);
            #1;
            start = 1'b1; start_addr = 32'h0000_0040;
            @(negedge clk);
            check(busy, "R9 walker busy at second start", 32'(busy), 32'd1);
            @(posedge clk); #1;
            start = 1'b0;
        end
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!done && t < 20000);
        check(done, "R8 completion pulse seen", 32'(done), 32'd1);
        check(cycles == 32'(exp_cost), "R5 cost total", cycles, 32'(exp_cost));
        check(exp_data_q.size() == 0, "R7 all payload words delivered", 32'(exp_data_q.size()), 32'd0);
        check(exp_addr_q.size() == 0, "R1 all nodes fetched", 32'(exp_addr_q.size()), 32'd0);
        @(negedge clk);
        check(!done, "R8 completion lasts one cycle", 32'(done), 32'd0);
        repeat (4) @(negedge clk);
        check(cycles == 32'(exp_cost), "R8 total held after walk", cycles, 32'(exp_cost));
        exp_cost = 0;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !out_valid && !mem_req, "R10 reset state idle",
              {28'd0, busy, done, out_valid, mem_req}, 32'd0);
        check(cycles == 0, "R8 reset total", cycles, 32'd0);

        // R2: end marker on the start pointer, upper byte ignored
        exp_cost = 0;
        run_chain(32'hAB80_0000, 1'b0);

        // R1 R3 R4 R5: three nodes, masked pointers, junk upper start byte
        lat = 1; rmode = 0;
        add_node(24'h000102, 8'd3, 24'h400200, 8'h11);
        add_node(24'h400200, 8'd0, 24'h000300, 8'h22);
        add_node(24'h000300, 8'd2, 24'hFFFFFF, 8'h33);
        run_chain(32'h5A00_0102, 1'b0);

        // R7 R9: slow memory, random backpressure, start poked while busy
        lat = 3; rmode = 1;
        add_node(24'h001000, 8'd4, 24'h002000, 8'h44);
        add_node(24'h002000, 8'd1, 24'h800000, 8'h55);
        run_chain(32'h0000_1000, 1'b1);

        // R6: payload wraps at the top of the 2 MB region, heavy stalls
        lat = 2; rmode = 2;
        add_node(24'h1FFFF8, 8'd2, 24'h1FFFF0, 8'h66);
        add_node(24'h1FFFF0, 8'd0, 24'h803456, 8'h77);
        run_chain(32'h001F_FFF8, 1'b0);

        // R5: maximum length node
        lat = 1; rmode = 1;
        add_node(24'h010000, 8'd255, 24'h810000, 8'h88);
        run_chain(32'h0001_0000, 1'b0);

        // R4: only zero-length nodes
        lat = 2; rmode = 0;
        add_node(24'h020000, 8'd0, 24'h020010, 8'h99);
        add_node(24'h020010, 8'd0, 24'hC00000, 8'hAA);
        run_chain(32'h0002_0000, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule